// File: doc/BRIEF.md
# Hardware Call and Interrupt Return Stack

This block saves a 16-bit program counter when a subroutine call or an interrupt entry occurs, and gives it back on the matching return. The counter is kept as two bytes in a byte-wide data RAM page. The page is the top page of the RAM, and the stack grows downward from its highest address. An 8-bit stack pointer selects the slot. Software can read the pointer and overwrite it at any moment.

Interrupt entries also save the status flags. These go into a four-entry stack held inside the block, so each nesting level keeps its own copy. Only an interrupt return takes flags back off this stack. A plain return never touches it.

The decoder issues one-cycle command pulses and waits while `busy_o` is high. The block drives the RAM address, write data and strobes. It expects the read data one cycle after a read strobe.

Top module: `sys_stack`

## Requirements
- R1: After reset the pointer reads 255, the flag stack is empty, and `pc_valid_o`, `flags_valid_o`, `ovf_o`, `unf_o` and `busy_o` are all low.
- R2: An accepted call or interrupt takes two cycles. The first cycle writes the PC low byte at the pointer. The second cycle writes the high byte at the pointer minus 1 and lowers the pointer by 2.
- R3: An accepted return raises the pointer by 2 and reads the low byte and then the high byte. Three cycles after acceptance, `pc_valid_o` pulses for one cycle with the restored PC. Restored values come back in last-in, first-out order.
- R4: An interrupt entry pushes `flags_i` onto the internal four-entry flag stack. An interrupt return pops it. When the restored PC appears, `flags_o` carries the popped flags and `flags_valid_o` pulses for one cycle.
- R5: A plain return leaves `flags_o` unchanged and does not pulse `flags_valid_o`. A call does not touch the flag stack.
- R6: A push is refused in two cases: the pointer is below 2, or the command is an interrupt and the flag stack already holds four entries. A refused push pulses `ovf_o` one cycle later, writes nothing and leaves the pointer unchanged.
- R7: A return is refused in two cases: the pointer is 254 or 255, or the command is an interrupt return and the flag stack is empty. A refused return pulses `unf_o` one cycle later, reads nothing, restores no PC and leaves the pointer unchanged.
- R8: A pointer write loads `sp_wdata_i` into the pointer, and `sp_o` shows it on the next cycle. The next push uses the new value as its address.
- R9: When commands arrive together, the order of precedence is interrupt, then call, then interrupt return, then return. Commands that arrive while `busy_o` is high are ignored.
- R10: Every RAM address has the `PAGE` parameter in its upper byte, which defaults to 0xFF. A read strobe and a write strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Subroutine call pulse |
| irq_i | input | 1 | Interrupt entry pulse |
| ret_i | input | 1 | Subroutine return pulse |
| reti_i | input | 1 | Interrupt return pulse |
| pc_i | input | 16 | Program counter to save |
| flags_i | input | 4 | Status flags to save on interrupt entry |
| sp_we_i | input | 1 | Software pointer write strobe |
| sp_wdata_i | input | 8 | Software pointer write value |
| sp_o | output | 8 | Current stack pointer |
| ram_addr_o | output | 16 | RAM byte address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_we_o | output | 1 | RAM write strobe |
| ram_re_o | output | 1 | RAM read strobe |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the read strobe |
| pc_o | output | 16 | Restored program counter |
| pc_valid_o | output | 1 | Restored PC valid pulse |
| flags_o | output | 4 | Restored flags |
| flags_valid_o | output | 1 | Restored flags valid pulse |
| busy_o | output | 1 | Sequence in progress |
| ovf_o | output | 1 | Refused push pulse |
| unf_o | output | 1 | Refused return pulse |

## Verification
The assertions check the following on every cycle:
- the pointer moves by exactly 2 at the end of a push and at the start of a pop;
- a refused command leaves the pointer where it was;
- a software write lands on the pointer;
- the flag stack never exceeds its depth;
- read and write strobes never overlap;
- a restored PC appears only after the last read.

Only the bench scenarios can show the following:
- that the bytes land at the right addresses and come back in last-in, first-out order across the whole page;
- that nested interrupts get their own flags back;
- that a plain return leaves the flags alone;
- that precedence and the busy lockout select the right command.

// File: rtl/sys_stack_pkg.sv
package sys_stack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PUSH_HI  = 2'd1,
    ST_POP_HI   = 2'd2,
    ST_POP_DONE = 2'd3
  } stk_state_e;
endpackage

// File: rtl/sys_stack_ptr.sv
module sys_stack_ptr #(
  parameter int unsigned SP_W = 8,
  parameter logic [SP_W-1:0] SP_TOP = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sw_we_i,
  input  logic [SP_W-1:0] sw_data_i,
  input  logic            dec2_i,
  input  logic            inc2_i,
  output logic [SP_W-1:0] sp_o
);
  localparam logic [SP_W-1:0] STEP = SP_W'(2);

  logic [SP_W-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_q <= SP_TOP;
    else if (sw_we_i) sp_q <= sw_data_i;  // software write wins
    else if (dec2_i)  sp_q <= sp_q - STEP;
    else if (inc2_i)  sp_q <= sp_q + STEP;
  end

  assign sp_o = sp_q;

  // R8
  sw_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> sp_q == $past(sw_data_i));
endmodule

// File: rtl/sys_stack_flagq.sv
module sys_stack_flagq #(
  parameter int unsigned FW    = 4,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [FW-1:0] data_i,
  output logic [FW-1:0] top_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [FW-1:0]    mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_idx;

  assign top_idx = cnt_q - CNT_W'(1);
  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign top_o   = mem_q[top_idx[IDX_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (push_i && !full_o) begin
      mem_q[cnt_q[IDX_W-1:0]] <= data_i;
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= top_idx;
    end
  end

  // R4
  flag_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  // R6
  flag_no_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R7
  flag_no_und_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/sys_stack.sv
module sys_stack
  import sys_stack_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SP_W        = 8,
  parameter int unsigned FW          = 4,
  parameter int unsigned FLAG_DEPTH  = 4,
  parameter logic [ADDR_W-SP_W-1:0] PAGE = '1,
  parameter logic [SP_W-1:0] SP_TOP  = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic              irq_i,
  input  logic              ret_i,
  input  logic              reti_i,
  input  logic [15:0]       pc_i,
  input  logic [FW-1:0]     flags_i,
  input  logic              sp_we_i,
  input  logic [SP_W-1:0]   sp_wdata_i,
  output logic [SP_W-1:0]   sp_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  input  logic [7:0]        ram_rdata_i,
  output logic [15:0]       pc_o,
  output logic              pc_valid_o,
  output logic [FW-1:0]     flags_o,
  output logic              flags_valid_o,
  output logic              busy_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam logic [SP_W-1:0] ONE = SP_W'(1);
  localparam logic [SP_W-1:0] TWO = SP_W'(2);

  stk_state_e      state_q, state_d;
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] addr_lo;
  logic            idle;
  logic            do_irq, do_call, do_reti, do_ret;
  logic            push_req, pop_req, push_bad, pop_bad, push_ok, pop_ok;
  logic            fq_full, fq_empty, fq_pop;
  logic [FW-1:0]   fq_top;
  logic [7:0]      hi_q, lo_q;
  logic            reti_q;
  logic [15:0]     pc_q;
  logic            pcv_q, fv_q, ovf_q, unf_q;
  logic [FW-1:0]   flags_q;

  assign idle    = (state_q == ST_IDLE);
  assign do_irq  = idle && irq_i;
  assign do_call = idle && !irq_i && call_i;
  assign do_reti = idle && !irq_i && !call_i && reti_i;
  assign do_ret  = idle && !irq_i && !call_i && !reti_i && ret_i;

  assign push_req = do_irq || do_call;
  assign pop_req  = do_reti || do_ret;
  assign push_bad = push_req && ((sp < TWO) || (do_irq && fq_full));
  assign pop_bad  = pop_req && ((sp >= SP_TOP - ONE) || (do_reti && fq_empty));
  assign push_ok  = push_req && !push_bad;
  assign pop_ok   = pop_req && !pop_bad;
  assign fq_pop   = (state_q == ST_POP_DONE) && reti_q;

  sys_stack_ptr #(.SP_W(SP_W), .SP_TOP(SP_TOP)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_we_i   (sp_we_i),
    .sw_data_i (sp_wdata_i),
    .dec2_i    (state_q == ST_PUSH_HI),
    .inc2_i    (pop_ok),
    .sp_o      (sp)
  );

  sys_stack_flagq #(.FW(FW), .DEPTH(FLAG_DEPTH)) u_flagq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (do_irq && push_ok),
    .pop_i   (fq_pop),
    .data_i  (flags_i),
    .top_o   (fq_top),
    .full_o  (fq_full),
    .empty_o (fq_empty)
  );

  always_comb begin
    state_d     = state_q;
    ram_we_o    = 1'b0;
    ram_re_o    = 1'b0;
    addr_lo     = sp;
    ram_wdata_o = hi_q;
    unique case (state_q)
      ST_IDLE: begin
        if (push_ok) begin
          ram_we_o    = 1'b1;
          ram_wdata_o = pc_i[7:0];
          state_d     = ST_PUSH_HI;
        end else if (pop_ok) begin
          ram_re_o = 1'b1;
          addr_lo  = sp + TWO;  // pointer moves up first
          state_d  = ST_POP_HI;
        end
      end
      ST_PUSH_HI: begin
        ram_we_o = 1'b1;
        addr_lo  = sp - ONE;
        state_d  = ST_IDLE;
      end
      ST_POP_HI: begin
        ram_re_o = 1'b1;
        addr_lo  = sp - ONE;
        state_d  = ST_POP_DONE;
      end
      ST_POP_DONE: state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign ram_addr_o = {PAGE, addr_lo};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hi_q    <= '0;
      lo_q    <= '0;
      reti_q  <= 1'b0;
      pc_q    <= '0;
      pcv_q   <= 1'b0;
      fv_q    <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      state_q <= state_d;
      ovf_q   <= push_bad;
      unf_q   <= pop_bad;
      pcv_q   <= 1'b0;
      fv_q    <= 1'b0;
      if (push_ok) hi_q <= pc_i[15:8];
      if (pop_ok)  reti_q <= do_reti;
      if (state_q == ST_POP_HI) lo_q <= ram_rdata_i;
      if (state_q == ST_POP_DONE) begin
        pc_q  <= {ram_rdata_i, lo_q};
        pcv_q <= 1'b1;
        if (reti_q) begin
          flags_q <= fq_top;
          fv_q    <= 1'b1;
        end
      end
    end
  end

  assign sp_o          = sp;
  assign pc_o          = pc_q;
  assign pc_valid_o    = pcv_q;
  assign flags_o       = flags_q;
  assign flags_valid_o = fv_q;
  assign busy_o        = !idle;
  assign ovf_o         = ovf_q;
  assign unf_o         = unf_q;

  // R2
  push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PUSH_HI && !sp_we_i) |=> sp == $past(sp) - TWO);
  // R3
  pop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && ram_re_o && !sp_we_i) |=> sp == $past(sp) + TWO);
  // R3
  pc_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pc_valid_o) |-> $past(state_q == ST_POP_DONE));
  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !$past(sp_we_i)) |-> $stable(sp) && $past(!ram_we_o));
  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_o && !$past(sp_we_i)) |-> $stable(sp) && $past(!ram_re_o));
  // R5
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_valid_o |-> $stable(flags_o));
  // R10
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && ram_re_o));
endmodule

// File: tb/sim_sys_stack.sv
module sim_sys_stack;
  localparam time HALF = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call, irq, ret, reti, sp_we;
  logic [15:0] pc;
  logic [3:0] flags;
  logic [7:0] sp_wd;
  logic [7:0] sp;
  logic [15:0] raddr;
  logic [7:0] rwd, rrd;
  logic rwe, rre;
  logic [15:0] pc_out;
  logic pcv, fv, busy, ovf, unf;
  logic [3:0] flags_out;

  int n_tests = 0;
  int n_fail  = 0;
  int bad_bus = 0;
  logic [7:0] mem [256];

  logic g_ovf, g_unf, g_pcv, g_fv;
  logic [15:0] g_pc;
  logic [3:0] g_flags;

  always #HALF clk = ~clk;

  sys_stack u0 (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .irq_i(irq), .ret_i(ret),
    .reti_i(reti), .pc_i(pc), .flags_i(flags), .sp_we_i(sp_we),
    .sp_wdata_i(sp_wd), .sp_o(sp), .ram_addr_o(raddr), .ram_wdata_o(rwd),
    .ram_we_o(rwe), .ram_re_o(rre), .ram_rdata_i(rrd), .pc_o(pc_out),
    .pc_valid_o(pcv), .flags_o(flags_out), .flags_valid_o(fv),
    .busy_o(busy), .ovf_o(ovf), .unf_o(unf)
  );

  // RAM model with one-cycle read latency
  always @(posedge clk) begin
    if (rwe) mem[raddr[7:0]] <= rwd;
    if (rre) rrd <= mem[raddr[7:0]];
    if ((rwe || rre) && raddr[15:8] != 8'hFF) bad_bus++;
    if (rwe && rre) bad_bus++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive one command pulse, then collect results over the following cycles
  task automatic run(input logic c, input logic i, input logic r, input logic ri);
    @(negedge clk);
    call = c; irq = i; ret = r; reti = ri;
    @(negedge clk);
    call = 0; irq = 0; ret = 0; reti = 0;
    g_ovf = ovf; g_unf = unf; g_pcv = 0; g_fv = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (pcv) begin g_pcv = 1; g_pc = pc_out; end
      if (fv)  begin g_fv = 1; g_flags = flags_out; end
    end
  endtask

  function automatic logic [15:0] pc_of(input int k);
    return 16'(k * 16'h0103 + 16'h1234);
  endfunction

  initial begin
    #(HALF * 2 * 200000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] e_sp;
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    rrd = 0;
    call = 0; irq = 0; ret = 0; reti = 0; sp_we = 0; sp_wd = 0; pc = 0; flags = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(sp == 8'hFF, "R1 sp", sp, 8'hFF);
    check(!pcv && !fv && !ovf && !unf && !busy, "R1 outs", {pcv, fv, ovf, unf, busy}, 0);
    // R1 flag stack empty: reti refused even with an entry on the PC stack
    pc = 16'h0F0F; run(1, 0, 0, 0);
    run(0, 0, 0, 1);
    check(g_unf && !g_pcv && sp == 8'hFD, "R1 R7 empty flag stack", {g_unf, g_pcv, sp}, {2'b10, 8'hFD});
    run(0, 0, 1, 0);
    check(g_pcv && g_pc == 16'h0F0F, "R3 single pop", g_pc, 16'h0F0F);

    // R2/R3 sweep of the whole page
    for (int k = 0; k < 127; k++) begin
      pc = pc_of(k);
      run(1, 0, 0, 0);
      e_sp = 8'(255 - 2 * (k + 1));
      check(sp == e_sp && !g_ovf, "R2 sp", sp, e_sp);
      check(mem[8'(255 - 2 * k)] == pc[7:0], "R2 low byte", mem[8'(255 - 2 * k)], pc[7:0]);
      check(mem[8'(254 - 2 * k)] == pc[15:8], "R2 high byte", mem[8'(254 - 2 * k)], pc[15:8]);
    end
    pc = 16'hDEAD;
    run(1, 0, 0, 0);
    check(g_ovf && sp == 8'h01, "R6 page overflow", {g_ovf, sp}, {1'b1, 8'h01});
    check(mem[1] != 8'hAD && mem[0] != 8'hDE, "R6 no write", {mem[1], mem[0]}, 0);
    for (int k = 126; k >= 0; k--) begin
      run(0, 0, 1, 0);
      check(g_pcv && g_pc == pc_of(k), "R3 LIFO pc", g_pc, pc_of(k));
      check(sp == 8'(255 - 2 * k), "R3 sp", sp, 8'(255 - 2 * k));
    end
    run(0, 0, 1, 0);
    check(g_unf && !g_pcv && sp == 8'hFF, "R7 pop at top", {g_unf, g_pcv, sp}, {2'b10, 8'hFF});

    // R4 nested interrupts with flags
    for (int k = 0; k < 4; k++) begin
      pc = pc_of(200 + k); flags = 4'(k + 5);
      run(0, 1, 0, 0);
      check(!g_ovf, "R4 irq push", g_ovf, 0);
    end
    e_sp = sp;
    pc = 16'hBEEF; flags = 4'hF;
    run(0, 1, 0, 0);
    check(g_ovf && sp == e_sp, "R6 flag stack full", {g_ovf, sp}, {1'b1, e_sp});
    // R5 call and return leave flags alone
    pc = 16'h7777; flags = 4'h3;
    run(1, 0, 0, 0);
    run(0, 0, 1, 0);
    check(g_pcv && g_pc == 16'h7777 && !g_fv && flags_out == 4'h0, "R5 ret keeps flags",
          {g_fv, flags_out}, 0);
    for (int k = 3; k >= 0; k--) begin
      run(0, 0, 0, 1);
      check(g_pcv && g_pc == pc_of(200 + k), "R4 reti pc", g_pc, pc_of(200 + k));
      check(g_fv && g_flags == 4'(k + 5) && flags_out == 4'(k + 5), "R4 reti flags", g_flags, 4'(k + 5));
    end
    run(0, 0, 0, 1);
    check(g_unf && !g_fv, "R7 reti at top", {g_unf, g_fv}, 2'b10);

    // R8 software pointer write
    @(negedge clk); sp_we = 1; sp_wd = 8'h40;
    @(negedge clk); sp_we = 0;
    check(sp == 8'h40, "R8 readback", sp, 8'h40);
    pc = 16'hC0DE; run(1, 0, 0, 0);
    check(mem[8'h40] == 8'hDE && mem[8'h3F] == 8'hC0 && sp == 8'h3E, "R8 push at new sp",
          {mem[8'h40], mem[8'h3F], sp}, {16'hC0DE, 8'h3E});
    @(negedge clk); sp_we = 1; sp_wd = 8'hFE;
    @(negedge clk); sp_we = 0;
    run(0, 0, 1, 0);
    check(g_unf && sp == 8'hFE, "R7 pop at 254", {g_unf, sp}, {1'b1, 8'hFE});
    @(negedge clk); sp_we = 1; sp_wd = 8'hFF;
    @(negedge clk); sp_we = 0;

    // R9 precedence: call beats ret, irq beats call
    pc = 16'h1111; run(1, 0, 1, 0);
    check(!g_unf && sp == 8'hFD, "R9 call over ret", sp, 8'hFD);
    pc = 16'h2222; flags = 4'hA; run(1, 1, 0, 0);
    run(0, 0, 0, 1);
    check(g_fv && g_flags == 4'hA && g_pc == 16'h2222, "R9 irq over call", {g_flags, g_pc}, {4'hA, 16'h2222});
    // R9 commands ignored while busy
    @(negedge clk); call = 1; pc = 16'h3333;
    @(negedge clk); call = 1; ret = 1;
    @(negedge clk); call = 0; ret = 0;
    repeat (3) @(negedge clk);
    check(sp == 8'hFB, "R9 busy ignore", sp, 8'hFB);
    run(0, 0, 1, 0);
    check(g_pc == 16'h3333 && sp == 8'hFD, "R9 after busy", g_pc, 16'h3333);
    run(0, 0, 1, 0);
    check(g_pc == 16'h1111 && sp == 8'hFF, "R9 drain", g_pc, 16'h1111);

    // R10 address page and strobe exclusivity
    check(bad_bus == 0, "R10 bus", bad_bus, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule